// File: doc/BRIEF.md
# Sixteen-Bit Timer and Event Counter

This block is a 16-bit up counter held as a low byte and a high byte. A source-select input chooses what makes it advance. In timer mode it advances once per machine cycle, and a machine cycle is twelve clocks of the oscillator that drives the block. In event mode it advances once for each falling edge on an external pin.

The pin is sampled once per machine cycle, always at the same phase. A falling edge counts only when one sample is high and the next sample is low. The counter changes part of the way into the machine cycle that follows the detection.

Software reads either byte through a combinational byte mux and can overwrite either byte. When the counter wraps, it sets a sticky overflow flag, which software clears. The pin is assumed to be synchronous to the clock.

Top module: `evt_timer16`

## Requirements
- R1: After reset both count bytes read 0x00 and `ovf` is 0. The internal phase count of the machine cycle restarts at 0.
- R2: `rd_data` returns count bits [7:0] when `rd_sel` is 0 and bits [15:0]'s upper byte [15:8] when `rd_sel` is 1. The read is combinational in the same cycle.
- R3: Phases are numbered 0..11. Phase 0 is the state on the first rising edge after reset is released, and the phase advances by one on every edge. With `src_event`=0 and `run`=1, the count rises by exactly one in every twelve clocks. The increment lands on the edge where the phase is 3.
- R4: With `src_event`=1, `cnt_pin` is sampled on the edge where the phase is 8. An increment is scheduled only when the previous sample was 1 and the new sample is 0. The sample history starts at 0 after reset.
- R5: Pin activity between two sampling edges is invisible. A low pulse that does not cover a sampling edge adds nothing, and at most one event is counted per machine cycle.
- R6: An increment scheduled on a phase-8 edge appears on the following phase-3 edge, seven clocks later. The count stays unchanged on the six edges in between.
- R7: If `run` is 0 on a phase-8 edge, no increment is scheduled for that machine cycle in either mode. The pin sample is still taken.
- R8: With `wr_en`=1, `wr_data` replaces the byte chosen by `wr_sel` (0 = low byte, 1 = high byte) on the next edge, and the other byte is kept. An increment due on that same edge is dropped.
- R9: An increment from 0xFFFF to 0x0000 sets `ovf`. The flag stays 1 until `ovf_clr` is 1 on an edge. If a set and a clear fall on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_pin | input | 1 | External event pin, synchronous to clk |
| src_event | input | 1 | 0 = count machine cycles, 1 = count pin falling edges |
| run | input | 1 | Enables scheduling of increments |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 1 | Byte chosen by a write |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Byte chosen for reading |
| rd_data | output | 8 | Selected count byte |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf | output | 1 | Sticky overflow flag |

## Verification
Each result has a fixed due time:
- A byte write and a flag change are due one edge after the stimulus.
- A read is due in the same cycle.
- An increment is due on the phase-3 edge, seven clocks after the phase-8 sample that scheduled it.

The bench keeps a per-clock reference of phase, sample, pending increment, count and flag that is derived from these timing rules. It applies inputs on the falling clock edge, advances the reference by one edge, and compares both bytes and the flag just after the next falling edge. Directed sequences also count the exact edges between detection and update and check the unchanged count in that gap.

// File: rtl/evt_timer16_pkg.sv
package evt_timer16_pkg;

    typedef enum logic {
        SRC_TIMER = 1'b0,
        SRC_EVENT = 1'b1
    } src_t;

    typedef struct packed {
        logic samp;
        logic pend;
    } edge_st_t;

endpackage

// File: rtl/evt_timer16_phase.sv
module evt_timer16_phase #(
    parameter int MC_CLKS   = 12,
    parameter int SAMPLE_PH = 8,
    parameter int UPDATE_PH = 3,
    localparam int PH_W     = $clog2(MC_CLKS)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase_o,
    output logic            samp_stb_o,
    output logic            upd_stb_o
);

    logic [PH_W-1:0] ph_d, ph_q;

    always_comb begin
        if (ph_q == PH_W'(MC_CLKS - 1)) begin
            ph_d = '0;
        end else begin
            ph_d = ph_q + PH_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign phase_o    = ph_q;
    assign samp_stb_o = (ph_q == PH_W'(SAMPLE_PH));
    assign upd_stb_o  = (ph_q == PH_W'(UPDATE_PH));

endmodule

// File: rtl/evt_timer16_edge.sv
module evt_timer16_edge
    import evt_timer16_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic samp_stb_i,
    input  logic upd_stb_i,
    input  logic pin_i,
    input  logic src_i,
    input  logic run_i,
    output logic inc_req_o
);

    edge_st_t st_d, st_q;
    logic     fall;

    always_comb begin
        st_d = st_q;
        fall = st_q.samp & ~pin_i;
        if (samp_stb_i) begin
            st_d.samp = pin_i;
            if (src_t'(src_i) == SRC_EVENT) begin
                st_d.pend = run_i & fall;
            end else begin
                st_d.pend = run_i;
            end
        end else if (upd_stb_i) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign inc_req_o = st_q.pend & upd_stb_i;

endmodule

// File: rtl/evt_timer16_core.sv
module evt_timer16_core #(
    parameter int WIDTH  = 16,
    parameter int BYTE_W = 8,
    localparam int NB    = WIDTH / BYTE_W,
    localparam int SELW  = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              wr_en_i,
    input  logic [SELW-1:0]   wr_sel_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic              ovf_clr_i,
    input  logic [SELW-1:0]   rd_sel_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic [WIDTH-1:0]  cnt_o,
    output logic              ovf_o
);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
        logic             ovf;
    } core_st_t;

    core_st_t          st_d, st_q;
    logic              bump;
    logic              wrap;
    logic [BYTE_W-1:0] byte_w [NB];

    always_comb begin
        st_d = st_q;
        bump = inc_i & ~wr_en_i;
        wrap = bump & (&st_q.cnt);
        if (bump) begin
            st_d.cnt = st_q.cnt + WIDTH'(1);
        end
        if (wr_en_i) begin
            for (int b = 0; b < NB; b++) begin
                if (wr_sel_i == SELW'(b)) begin
                    st_d.cnt[b*BYTE_W +: BYTE_W] = wr_data_i;
                end
            end
        end
        if (ovf_clr_i) begin
            st_d.ovf = 1'b0;
        end
        if (wrap) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NB; g++) begin : g_rd_byte
        assign byte_w[g] = st_q.cnt[g*BYTE_W +: BYTE_W];
    end

    assign rd_data_o = byte_w[rd_sel_i];
    assign cnt_o     = st_q.cnt;
    assign ovf_o     = st_q.ovf;

endmodule

// File: rtl/evt_timer16.sv
module evt_timer16 #(
    parameter int WIDTH     = 16,
    parameter int BYTE_W    = 8,
    parameter int MC_CLKS   = 12,
    parameter int SAMPLE_PH = 8,
    parameter int UPDATE_PH = 3,
    localparam int NB       = WIDTH / BYTE_W,
    localparam int SELW     = (NB > 1) ? $clog2(NB) : 1,
    localparam int PH_W     = $clog2(MC_CLKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_pin,
    input  logic              src_event,
    input  logic              run,
    input  logic              wr_en,
    input  logic [SELW-1:0]   wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [SELW-1:0]   rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              ovf_clr,
    output logic              ovf
);

    logic [PH_W-1:0]  phase_w;
    logic             samp_stb;
    logic             upd_stb;
    logic             inc_req;
    logic [WIDTH-1:0] cnt_w;

    evt_timer16_phase #(
        .MC_CLKS  (MC_CLKS),
        .SAMPLE_PH(SAMPLE_PH),
        .UPDATE_PH(UPDATE_PH)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_o   (phase_w),
        .samp_stb_o(samp_stb),
        .upd_stb_o (upd_stb)
    );

    evt_timer16_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_stb_i(samp_stb),
        .upd_stb_i (upd_stb),
        .pin_i     (cnt_pin),
        .src_i     (src_event),
        .run_i     (run),
        .inc_req_o (inc_req)
    );

    evt_timer16_core #(
        .WIDTH (WIDTH),
        .BYTE_W(BYTE_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_i    (inc_req),
        .wr_en_i  (wr_en),
        .wr_sel_i (wr_sel),
        .wr_data_i(wr_data),
        .ovf_clr_i(ovf_clr),
        .rd_sel_i (rd_sel),
        .rd_data_o(rd_data),
        .cnt_o    (cnt_w),
        .ovf_o    (ovf)
    );

endmodule

// File: rtl/evt_timer16_chk.sv
module evt_timer16_chk #(
    parameter int WIDTH     = 16,
    parameter int BYTE_W    = 8,
    parameter int SELW      = 1,
    parameter int PH_W      = 4,
    parameter int UPDATE_PH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [SELW-1:0]   wr_sel,
    input logic [BYTE_W-1:0] wr_data,
    input logic              ovf_clr,
    input logic [WIDTH-1:0]  cnt,
    input logic              ovf,
    input logic [PH_W-1:0]   phase
);

    // R8
    wr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == '0) |=> (cnt[BYTE_W-1:0] == $past(wr_data)));

    // R6
    quiet_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && phase != PH_W'(UPDATE_PH)) |=> $stable(cnt));

    // R3
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (cnt == $past(cnt) || cnt == $past(cnt) + WIDTH'(1)));

    // R9
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    // R9
    ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> (cnt == '0));

endmodule

bind evt_timer16 evt_timer16_chk #(
    .WIDTH    (WIDTH),
    .BYTE_W   (BYTE_W),
    .SELW     (SELW),
    .PH_W     (PH_W),
    .UPDATE_PH(UPDATE_PH)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_data(wr_data),
    .ovf_clr(ovf_clr),
    .cnt    (cnt_w),
    .ovf    (ovf),
    .phase  (phase_w)
);

// File: tb/evt_timer16_bench.sv
module evt_timer16_bench;

    localparam int MC   = 12;
    localparam int SAMP = 8;
    localparam int UPD  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_pin = 1'b0;
    logic       src_event = 1'b0;
    logic       run = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       ovf_clr = 1'b0;
    logic       ovf;

    int errors = 0;
    int checks = 0;

    int        mph = 0;
    bit        msamp = 1'b0;
    bit        mpend = 1'b0;
    bit [15:0] mcnt = 16'h0000;
    bit        movf = 1'b0;

    always #10 clk = ~clk;

    evt_timer16 u_evt_timer16 (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_pin  (cnt_pin),
        .src_event(src_event),
        .run      (run),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .ovf_clr  (ovf_clr),
        .ovf      (ovf)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic read_cnt(output bit [15:0] v);
        rd_sel = 1'b0;
        #1;
        v[7:0] = rd_data;
        rd_sel = 1'b1;
        #1;
        v[15:8] = rd_data;
    endtask

    task automatic compare_model();
        rd_sel = 1'b0;
        #1;
        check("R2 low byte", rd_data, mcnt[7:0]);
        rd_sel = 1'b1;
        #1;
        check("R2 high byte", rd_data, mcnt[15:8]);
        check("R9 flag", ovf, movf);
    endtask

    // Advance the reference by one edge from the current inputs (R3..R9).
    function automatic void model_edge(bit we, bit ws, bit [7:0] wd, bit clr);
        bit inc;
        bit setf;
        inc  = 1'b0;
        setf = 1'b0;
        if (mph == UPD) begin
            inc   = mpend;
            mpend = 1'b0;
        end
        if (mph == SAMP) begin
            mpend = run && (src_event ? (msamp && !cnt_pin) : 1'b1);
            msamp = cnt_pin;
        end
        if (we) begin
            if (ws) mcnt[15:8] = wd;
            else    mcnt[7:0]  = wd;
        end else if (inc) begin
            if (mcnt == 16'hFFFF) setf = 1'b1;
            mcnt = mcnt + 16'd1;
        end
        if (clr)  movf = 1'b0;
        if (setf) movf = 1'b1;
        mph = (mph + 1) % MC;
    endfunction

    task automatic step(input bit we = 0, input bit ws = 0,
                        input bit [7:0] wd = 8'h00, input bit clr = 0);
        wr_en   = we;
        wr_sel  = ws;
        wr_data = wd;
        ovf_clr = clr;
        model_edge(we, ws, wd, clr);
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
        ovf_clr = 1'b0;
        compare_model();
    endtask

    task automatic step_to(input int ph);
        while (mph != ph) step();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        bit [15:0] c0;
        bit [15:0] c1;
        repeat (3) @(negedge clk);
        // R1: reset values
        read_cnt(c0);
        check("R1 count", c0, 16'h0000);
        check("R1 flag", ovf, 0);
        rst_n = 1'b1;

        // R3: one step per twelve clocks
        src_event = 1'b0;
        run = 1'b1;
        repeat (30) step();
        step_to(UPD + 1);
        for (int k = 0; k < 3; k++) begin
            read_cnt(c0);
            repeat (MC) step();
            read_cnt(c1);
            check("R3 twelve clock rate", c1 - c0, 1);
        end

        // R7: run low at sampling, nothing scheduled
        run = 1'b0;
        step_to(SAMP + 1);
        read_cnt(c0);
        repeat (3 * MC) step();
        read_cnt(c1);
        check("R7 stopped", c1, c0);

        // R4/R6: falling edge latency in event mode
        src_event = 1'b1;
        run = 1'b1;
        cnt_pin = 1'b1;
        repeat (2 * MC) step();
        step_to(SAMP);
        cnt_pin = 1'b0;
        read_cnt(c0);
        step();
        for (int k = 0; k < 6; k++) begin
            step();
            read_cnt(c1);
            check("R6 held before update", c1, c0);
        end
        step();
        read_cnt(c1);
        check("R4 R6 edge counted", c1, c0 + 16'd1);

        // R5: short low pulse between samples
        cnt_pin = 1'b1;
        repeat (2 * MC) step();
        step_to(SAMP + 2);
        read_cnt(c0);
        cnt_pin = 1'b0;
        repeat (3) step();
        cnt_pin = 1'b1;
        repeat (2 * MC) step();
        read_cnt(c1);
        check("R5 glitch ignored", c1, c0);

        // R8: write wins over same-edge increment
        src_event = 1'b0;
        repeat (MC) step();
        step_to(UPD);
        read_cnt(c0);
        step(1, 0, 8'h55);
        read_cnt(c1);
        check("R8 low byte written", c1[7:0], 8'h55);
        check("R8 high byte kept", c1[15:8], c0[15:8]);

        // R9: wrap sets flag, flag sticks, set beats clear
        step(1, 1, 8'hFF);
        step(1, 0, 8'hFF);
        step_to(UPD + 1);
        read_cnt(c1);
        check("R9 wrapped count", c1, 16'h0000);
        check("R9 set on wrap", ovf, 1);
        repeat (2 * MC) step();
        check("R9 sticky", ovf, 1);
        step(1, 1, 8'hFF);
        step(1, 0, 8'hFF);
        step_to(UPD);
        step(0, 0, 8'h00, 1);
        check("R9 set wins over clear", ovf, 1);
        step(0, 0, 8'h00, 1);
        check("R9 cleared", ovf, 0);

        // Random phase: mixed modes, writes, clears, pin activity
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 6000; i++) begin
            bit we;
            if ($urandom_range(0, 99) < 2) src_event = ~src_event;
            if ($urandom_range(0, 99) < 3) run = ~run;
            if ($urandom_range(0, 99) < 15) cnt_pin = ~cnt_pin;
            we = ($urandom_range(0, 99) < 2);
            step(we, 1'($urandom_range(0, 1)),
                 (we && $urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom),
                 ($urandom_range(0, 99) < 2));
        end
        summary();
    end

endmodule